// File: doc/BRIEF.md
# Shifted Operand Generator

This block forms the second source operand of a 32-bit data-processing instruction and the carry bit the shifter produces alongside it. It reads the fixed fields of the instruction word itself. When the immediate flag is set, it builds a rotated 8-bit constant. Otherwise it takes a register value and passes it through one of four shift kinds. The shift amount arrives on a port of its own.

The block owns the read-index side of one register-file port. When the selected source register is the program counter, it swaps the register-file data for the program-counter view advanced by one word. The carry is offered to the flag register together with a commit strobe. That strobe follows the instruction's set-flags bit.

The block has no state. Operand, carry and strobe follow the inputs within the same cycle.

Top module: `shift_operand_gen`

## Requirements
- R1: `src_idx` always equals instruction bits 3:0.
- R2: With instruction bit 25 set (immediate form), `operand` is instruction bits 7:0, zero-extended to 32 bits and rotated right by twice the value of bits 11:8.
- R3: In the immediate form, `carry_out` equals `carry_in` when bits 11:8 are zero; otherwise it equals bit 31 of `operand`.
- R4: With bit 25 clear, bits 6:5 select the shift applied to the source value by `shamt`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R5: When bits 3:0 equal 15, the source value is `pc_view + 4` and `src_data` is ignored.
- R6: A register-form shift with `shamt` of zero passes the source value through unchanged and sets `carry_out` to `carry_in`, for every shift kind.
- R7: A nonzero register-form shift sets `carry_out` to the last bit shifted out: source bit 32-n for a left shift, and source bit n-1 for both right shifts and the rotate.
- R8: `carry_wr` equals instruction bit 20 (set-flags). That bit has no effect on `operand` or `carry_out`.
- R9: Instruction bits other than 25, 20, 11:8, 7:0, 6:5 and 3:0 have no effect on the outputs. In the register form, bits 11:8 and 7 also have no effect.
- R10: The outputs settle within the same cycle as the inputs, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| src_idx | output | 4 | Register-file read index for the source register |
| src_data | input | 32 | Register-file read data for `src_idx` |
| pc_view | input | 32 | Program-counter view as seen by the execute stage |
| shamt | input | 5 | Shift amount for the register form |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |
| carry_wr | output | 1 | Commit strobe for `carry_out` into the flag register |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 4-bit register index and a program-counter advance of 4. These values make every boundary reachable with a 5-bit shift amount. That covers a shift of zero for all four kinds, shifts of one and of 31, the rotations that wrap the immediate across bit 31, and the index that selects the program counter. Each vector pairs one shift kind or rotation with a source value whose carried-out bit differs from the incoming carry. This way a carry taken from the wrong bit, or passed through when it should not be, shows on the port.

// File: rtl/shift_operand_gen_pkg.sv
package shift_operand_gen_pkg;

    localparam int XLEN       = 32;
    localparam int IDX_W      = 4;
    localparam int IMM_W      = 8;
    localparam int ROT_W      = 4;
    localparam int SHAMT_W    = $clog2(XLEN);

    // Instruction field positions decoded by this block.
    localparam int IMM_FLAG_BIT = 25;
    localparam int SETF_BIT     = 20;
    localparam int ROT_LSB      = 8;
    localparam int KIND_LSB     = 5;
    localparam int SRC_LSB      = 0;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] operand;
        logic            carry;
        logic            carry_wr;
    } opnd_res_t;

endpackage

// File: rtl/sog_src_select.sv
module sog_src_select #(
    parameter int XLEN     = 32,
    parameter int IDX_W    = 4,
    parameter int PC_AHEAD = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  rf_data,
    input  logic [XLEN-1:0]  pc_view,
    output logic [XLEN-1:0]  value
);
    localparam logic [IDX_W-1:0] PC_IDX   = {IDX_W{1'b1}};
    localparam logic [XLEN-1:0]  PC_BUMP  = XLEN'(PC_AHEAD);

    always_comb begin
        if (idx == PC_IDX) value = pc_view + PC_BUMP;
        else               value = rf_data;
    end
endmodule

// File: rtl/sog_imm_rotator.sv
module sog_imm_rotator #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [ROT_W-1:0] rot,
    input  logic             cin,
    output logic [XLEN-1:0]  value,
    output logic             cout
);
    localparam int AMT_W = ROT_W + 1;

    logic [XLEN-1:0]   imm_ext;
    logic [2*XLEN-1:0] dbl;
    logic [AMT_W-1:0]  amt;

    always_comb begin
        imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
        amt     = {rot, 1'b0};
        dbl     = {imm_ext, imm_ext} >> amt;
        value   = dbl[XLEN-1:0];
        cout    = (rot == '0) ? cin : value[XLEN-1];
    end
endmodule

// File: rtl/sog_shifter.sv
module sog_shifter
    import shift_operand_gen_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [XLEN-1:0]    value_in,
    input  shift_kind_e        kind,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               cin,
    output logic [XLEN-1:0]    value_out,
    output logic               cout
);
    logic [XLEN:0]     ext_d;
    logic [2*XLEN-1:0] dbl_d;

    always_comb begin
        ext_d     = '0;
        dbl_d     = '0;
        value_out = value_in;
        cout      = cin;
        if (amt != '0) begin
            unique case (kind)
                SK_LSL: begin
                    ext_d     = {1'b0, value_in} << amt;
                    value_out = ext_d[XLEN-1:0];
                    cout      = ext_d[XLEN];
                end
                SK_LSR: begin
                    ext_d     = {value_in, 1'b0} >> amt;
                    value_out = ext_d[XLEN:1];
                    cout      = ext_d[0];
                end
                SK_ASR: begin
                    ext_d     = $unsigned($signed({value_in, 1'b0}) >>> amt);
                    value_out = ext_d[XLEN:1];
                    cout      = ext_d[0];
                end
                SK_ROR: begin
                    dbl_d     = {value_in, value_in} >> amt;
                    value_out = dbl_d[XLEN-1:0];
                    cout      = dbl_d[XLEN-1];
                end
                default: begin
                    value_out = value_in;
                    cout      = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shift_operand_gen.sv
module shift_operand_gen
    import shift_operand_gen_pkg::*;
#(
    parameter int PC_AHEAD = 4
) (
    input  logic [XLEN-1:0]    instr,
    output logic [IDX_W-1:0]   src_idx,
    input  logic [XLEN-1:0]    src_data,
    input  logic [XLEN-1:0]    pc_view,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               carry_in,
    output logic [XLEN-1:0]    operand,
    output logic               carry_out,
    output logic               carry_wr
);
    logic [XLEN-1:0] src_val;
    logic [XLEN-1:0] imm_val;
    logic            imm_c;
    logic [XLEN-1:0] sh_val;
    logic            sh_c;
    shift_kind_e     kind;
    opnd_res_t       res_d;

    assign src_idx = instr[SRC_LSB +: IDX_W];
    assign kind    = shift_kind_e'(instr[KIND_LSB +: 2]);

    sog_src_select #(
        .XLEN(XLEN), .IDX_W(IDX_W), .PC_AHEAD(PC_AHEAD)
    ) u_src (
        .idx     (src_idx),
        .rf_data (src_data),
        .pc_view (pc_view),
        .value   (src_val)
    );

    sog_imm_rotator #(
        .XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)
    ) u_imm (
        .imm   (instr[IMM_W-1:0]),
        .rot   (instr[ROT_LSB +: ROT_W]),
        .cin   (carry_in),
        .value (imm_val),
        .cout  (imm_c)
    );

    sog_shifter #(
        .XLEN(XLEN), .SHAMT_W(SHAMT_W)
    ) u_shf (
        .value_in  (src_val),
        .kind      (kind),
        .amt       (shamt),
        .cin       (carry_in),
        .value_out (sh_val),
        .cout      (sh_c)
    );

    always_comb begin
        res_d          = '0;
        res_d.carry_wr = instr[SETF_BIT];
        if (instr[IMM_FLAG_BIT]) begin
            res_d.operand = imm_val;
            res_d.carry   = imm_c;
        end else begin
            res_d.operand = sh_val;
            res_d.carry   = sh_c;
        end
    end

    assign operand   = res_d.operand;
    assign carry_out = res_d.carry;
    assign carry_wr  = res_d.carry_wr;

endmodule

// File: rtl/shift_operand_gen_chk.sv
module shift_operand_gen_chk
    import shift_operand_gen_pkg::*;
#(
    parameter int PC_AHEAD = 4
) (
    input logic [XLEN-1:0]    instr,
    input logic [IDX_W-1:0]   src_idx,
    input logic [XLEN-1:0]    pc_view,
    input logic [SHAMT_W-1:0] shamt,
    input logic               carry_in,
    input logic [XLEN-1:0]    operand,
    input logic               carry_out,
    input logic               carry_wr
);
    logic known;
    logic is_imm;
    logic [ROT_W-1:0] rot;
    logic [1:0] kbits;

    always_comb begin
        known  = !$isunknown({instr, pc_view, shamt, carry_in, src_idx,
                              operand, carry_out, carry_wr});
        is_imm = instr[IMM_FLAG_BIT];
        rot    = instr[ROT_LSB +: ROT_W];
        kbits  = instr[KIND_LSB +: 2];
        if (known) begin
            a_r1_src_index: assert (src_idx == instr[3:0]);
            a_r8_commit_strobe: assert (carry_wr == instr[SETF_BIT]);
            a_r3_imm_norot: assert (!(is_imm && rot == '0) ||
                (operand == {{(XLEN-IMM_W){1'b0}}, instr[IMM_W-1:0]} &&
                 carry_out == carry_in));
            a_r3_imm_rot_carry: assert (!(is_imm && rot != '0) ||
                carry_out == operand[XLEN-1]);
            a_r6_zero_shift_carry: assert (!(!is_imm && shamt == '0) ||
                carry_out == carry_in);
            a_r5_pc_source: assert (!(!is_imm && shamt == '0 &&
                instr[3:0] == 4'hF) || operand == pc_view + XLEN'(PC_AHEAD));
            a_r7_ror_carry: assert (!(!is_imm && shamt != '0 &&
                kbits == 2'b11) || carry_out == operand[XLEN-1]);
        end
    end
endmodule

bind shift_operand_gen shift_operand_gen_chk #(.PC_AHEAD(PC_AHEAD)) u_chk (
    .instr     (instr),
    .src_idx   (src_idx),
    .pc_view   (pc_view),
    .shamt     (shamt),
    .carry_in  (carry_in),
    .operand   (operand),
    .carry_out (carry_out),
    .carry_wr  (carry_wr)
);

// File: tb/shift_operand_gen_bench.sv
module shift_operand_gen_bench;
    import shift_operand_gen_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] instr;
    logic [3:0]  src_idx;
    logic [31:0] src_data;
    logic [31:0] pc_view;
    logic [4:0]  shamt;
    logic        carry_in;
    logic [31:0] operand;
    logic        carry_out;
    logic        carry_wr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    shift_operand_gen u_shift_operand_gen (
        .instr     (instr),
        .src_idx   (src_idx),
        .src_data  (src_data),
        .pc_view   (pc_view),
        .shamt     (shamt),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out),
        .carry_wr  (carry_wr)
    );

    // {instr, src_data, pc_view, shamt, cin, exp_operand, exp_carry, exp_wr, req}
    localparam int NV = 14;
    localparam logic [143:0] VEC [NV] = '{
        // R2 R3: no rotation, carry passes through
        {32'h020000FF, 32'h0, 32'h0, 5'd0, 1'b1, 32'h000000FF, 1'b1, 1'b0, 8'd2},
        // R2 R3: rotate 2, value wraps to bit 31, set-flags on
        {32'h02100102, 32'h0, 32'h0, 5'd0, 1'b0, 32'h80000000, 1'b1, 1'b1, 8'd3},
        // R2: rotate 30
        {32'h02000FF0, 32'h0, 32'h0, 5'd0, 1'b1, 32'h000003C0, 1'b0, 1'b0, 8'd2},
        // R2: rotate 8
        {32'h020004AB, 32'h0, 32'h0, 5'd0, 1'b0, 32'hAB000000, 1'b1, 1'b0, 8'd2},
        // R4: logical left 1
        {32'h00000002, 32'h80000001, 32'h0, 5'd1, 1'b0, 32'h00000002, 1'b1, 1'b0, 8'd4},
        // R4: logical right 1
        {32'h00000022, 32'h80000001, 32'h0, 5'd1, 1'b0, 32'h40000000, 1'b1, 1'b0, 8'd4},
        // R4: arithmetic right 4
        {32'h00000042, 32'h80000001, 32'h0, 5'd4, 1'b1, 32'hF8000000, 1'b0, 1'b0, 8'd4},
        // R4: rotate right 1
        {32'h00000062, 32'h80000001, 32'h0, 5'd1, 1'b0, 32'hC0000000, 1'b1, 1'b0, 8'd4},
        // R6: logical right by zero
        {32'h00100022, 32'h80000001, 32'h0, 5'd0, 1'b0, 32'h80000001, 1'b0, 1'b1, 8'd6},
        // R5: program counter source, no shift
        {32'h0000000F, 32'hDEADBEEF, 32'h00001000, 5'd0, 1'b1, 32'h00001004, 1'b1, 1'b0, 8'd5},
        // R5: program counter source, logical right 2
        {32'h0000002F, 32'hDEADBEEF, 32'h00000100, 5'd2, 1'b1, 32'h00000041, 1'b0, 1'b0, 8'd5},
        // R7: logical left 31
        {32'h00000002, 32'h00000003, 32'h0, 5'd31, 1'b0, 32'h80000000, 1'b1, 1'b0, 8'd7},
        // R7: logical right 31
        {32'h00000022, 32'h80000000, 32'h0, 5'd31, 1'b1, 32'h00000001, 1'b0, 1'b0, 8'd7},
        // R9: unrelated bits set, rotate right 1
        {32'hFDFFF062, 32'h80000001, 32'h0, 5'd1, 1'b0, 32'hC0000000, 1'b1, 1'b1, 8'd9}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] d,
                         input logic [31:0] p, input logic [4:0] s,
                         input logic c);
        @(negedge clk);
        instr = i; src_data = d; pc_view = p; shamt = s; carry_in = c;
        #1;
    endtask

    initial begin
        instr = '0; src_data = '0; pc_view = '0; shamt = '0; carry_in = 1'b0;

        // Idle state with all inputs at zero (R1 R8)
        apply(32'h0, 32'h0, 32'h0, 5'd0, 1'b0);
        chk(operand, 32'h0, "R4 idle operand");
        chk({31'b0, carry_out}, 32'h0, "R6 idle carry");
        chk({31'b0, carry_wr}, 32'h0, "R8 idle strobe");
        chk({28'b0, src_idx}, 32'h0, "R1 idle index");

        for (int k = 0; k < NV; k++) begin
            logic [143:0] v;
            string tag;
            v = VEC[k];
            apply(v[143:112], v[111:80], v[79:48], v[47:43], v[42]);
            tag = $sformatf("R%0d vector %0d", v[7:0], k);
            chk(operand, v[41:10], {tag, " operand"});
            chk({31'b0, carry_out}, {31'b0, v[9]}, {tag, " carry"});
            chk({31'b0, carry_wr}, {31'b0, v[8]}, {tag, " R8 strobe"});
            chk({28'b0, src_idx}, {28'b0, v[143:112] & 32'hF}, {tag, " R1 index"});
        end

        // R8: clearing set-flags leaves operand and carry as they were
        apply(32'h00000022, 32'h80000001, 32'h0, 5'd1, 1'b0);
        chk(operand, 32'h40000000, "R8 operand without set-flags");
        chk({31'b0, carry_out}, 32'h1, "R8 carry without set-flags");
        chk({31'b0, carry_wr}, 32'h0, "R8 strobe low");

        // R6: zero shift for left, arithmetic right and rotate
        apply(32'h00000042, 32'h80000001, 32'h0, 5'd0, 1'b1);
        chk(operand, 32'h80000001, "R6 arith zero operand");
        chk({31'b0, carry_out}, 32'h1, "R6 arith zero carry");
        apply(32'h00000062, 32'h80000001, 32'h0, 5'd0, 1'b0);
        chk(operand, 32'h80000001, "R6 rotate zero operand");
        chk({31'b0, carry_out}, 32'h0, "R6 rotate zero carry");

        // R5: data from the register file is ignored for index 15
        apply(32'h0000000F, 32'h12345678, 32'h00000FFC, 5'd0, 1'b0);
        chk(operand, 32'h00001000, "R5 pc source ignores data");

        // R9: rotation field ignored in register form
        apply(32'h00000F82, 32'h00000010, 32'h0, 5'd0, 1'b0);
        chk(operand, 32'h00000010, "R9 register form ignores bits 11:7");

        // R10: change inputs without any clock edge, outputs follow
        @(posedge clk);
        #1;
        instr = 32'h02000001; carry_in = 1'b1;
        #0.5;
        chk(operand, 32'h00000001, "R10 same-cycle operand");
        src_data = 32'h00000008; instr = 32'h00000002; shamt = 5'd4;
        #0.5;
        chk(operand, 32'h00000080, "R10 same-cycle shifted operand");
        chk({31'b0, carry_out}, 32'h0, "R10 same-cycle carry");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule